// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two independent predictors and a chooser. The first is a two-level local predictor. A table of per-branch outcome histories, selected by fetch-address bits, supplies a history pattern. That pattern then indexes a table of 3-bit saturating counters. The second is a global predictor: a table of 2-bit counters indexed by a speculative record of recent branch outcomes. A third table of 2-bit counters, indexed by the same global record, decides per branch which of the two results becomes the final prediction.

The prediction is formed combinationally from the fetch address and the current state. Alongside the final bit, the block returns both component results, the global history, and the local history it used. The fetch side keeps these and hands them back through the resolve port once the branch executes. The resolve port trains the tables using those returned values. The global history register shifts in each prediction as it is made. On a misprediction it is rebuilt from the returned history with the real outcome appended.

Top module: `tournament_bp`

## Requirements
- R1: After reset the global history is all zeros and every local history entry is zero. Each local counter resets to 3 (weakly not-taken). Each global and choice counter resets to 1, which for the chooser means weakly prefer local. The first prediction after reset is therefore not-taken with pred_use_global = 0.
- R2: The local history entry is chosen by pred_pc bits [PC_SKIP +: LHT_IDX_W] and appears on pred_lhist. It indexes the local counter table. The global and choice counters are indexed by the current global history, shown on pred_ghist. A component predicts taken when the most significant bit of its counter is 1.
- R3: pred_use_global equals the most significant bit of the choice counter. pred_taken equals pred_global when it is 1, and pred_local otherwise.
- R4: A cycle with pred_valid high and no repair shifts the global history left, with pred_taken entering at bit 0. The new value is visible from the next cycle.
- R5: A cycle with res_valid and res_mispredict high loads the global history with {res_ghist[GH_W-2:0], res_taken}. This takes priority over a simultaneous prediction.
- R6: With neither a prediction nor a repair, the global history keeps its value.
- R7: A cycle with res_valid shifts res_taken into bit 0 of the local history entry selected by res_pc bits [PC_SKIP +: LHT_IDX_W].
- R8: A cycle with res_valid steps the local counter at res_lhist and the global counter at res_ghist by one toward res_taken. The counters saturate at 0 and at all ones.
- R9: The choice counter at res_ghist changes only when res_local differs from res_global. It steps up by one (saturating) when res_global equals res_taken, and down by one (saturating) otherwise.
- R10: The tables change only in cycles with res_valid. With res_valid low and pred_pc and global history unchanged, every prediction output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A prediction is consumed this cycle |
| pred_pc | input | PC_W | Fetch address of the branch |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| pred_use_global | output | 1 | Chooser selected the global component |
| pred_ghist | output | GH_W | Global history used for this prediction |
| pred_lhist | output | LH_W | Local history used for this prediction |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_mispredict | input | 1 | Final prediction was wrong; repair history |
| res_ghist | input | GH_W | Global history returned from prediction |
| res_lhist | input | LH_W | Local history returned from prediction |
| res_local | input | 1 | Local component result returned from prediction |
| res_global | input | 1 | Global component result returned from prediction |

## Verification
The bench builds the block with an 8-bit address, a 4-entry local history table of 3-bit histories, 3-bit local counters and a 3-bit global history. All tables therefore have eight entries or fewer. The bench reference model is small enough that a few hundred batches of one to three in-flight predictions can do several things. They drive every counter into both saturation limits, exercise chooser training in both directions, and alias branches onto shared history entries. They also repair the speculative history many times, including a repair that collides with a new prediction.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [1:0] {
    TRAIN_HOLD = 2'd0,
    TRAIN_UP   = 2'd1,
    TRAIN_DOWN = 2'd2
  } train_e;
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  train_e           wr_op
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur_val;
  logic [CTR_W-1:0] nxt_val;

  assign rd_ctr  = mem[rd_idx];
  assign cur_val = mem[wr_idx];

  always_comb begin
    nxt_val = cur_val;
    case (wr_op)
      TRAIN_UP:   if (cur_val != CTR_MAX) nxt_val = cur_val + 1'b1;
      TRAIN_DOWN: if (cur_val != '0)      nxt_val = cur_val - 1'b1;
      default:    nxt_val = cur_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_val;
    end
  end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W = 10,
  parameter int H_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [H_W-1:0]   rd_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0] mem [DEPTH];
  logic [H_W-1:0] nxt_hist;

  assign rd_hist = mem[rd_idx];

  always_comb nxt_hist = {mem[wr_idx][H_W-2:0], wr_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_hist;
    end
  end
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
  parameter int GH_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spec_en,
  input  logic            spec_bit,
  input  logic            fix_en,
  input  logic [GH_W-1:0] fix_hist,
  input  logic            fix_bit,
  output logic [GH_W-1:0] hist
);
  logic [GH_W-1:0] hist_q;
  logic [GH_W-1:0] hist_d;
  logic            hist_en;

  always_comb begin
    hist_en = fix_en | spec_en;
    if (fix_en) hist_d = {fix_hist[GH_W-2:0], fix_bit};
    else        hist_d = {hist_q[GH_W-2:0], spec_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_SKIP   = 2,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int LCTR_W    = 3,
  parameter int GH_W      = 12,
  parameter int GCTR_W    = 2,
  parameter int CCTR_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  output logic            pred_use_global,
  output logic [GH_W-1:0] pred_ghist,
  output logic [LH_W-1:0] pred_lhist,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic            res_mispredict,
  input  logic [GH_W-1:0] res_ghist,
  input  logic [LH_W-1:0] res_lhist,
  input  logic            res_local,
  input  logic            res_global
);
  logic [LHT_IDX_W-1:0] pred_lht_idx;
  logic [LHT_IDX_W-1:0] res_lht_idx;
  logic [LCTR_W-1:0]    lctr;
  logic [GCTR_W-1:0]    gctr;
  logic [CCTR_W-1:0]    cctr;
  logic [GH_W-1:0]      ghist;
  logic [LH_W-1:0]      lhist;
  train_e               dir_op;
  train_e               choice_op;
  logic                 choice_wr;
  logic                 unused_pc_bits;

  assign pred_lht_idx   = pred_pc[PC_SKIP +: LHT_IDX_W];
  assign res_lht_idx    = res_pc[PC_SKIP +: LHT_IDX_W];
  assign unused_pc_bits = ^{pred_pc, res_pc};

  always_comb begin
    dir_op    = res_taken ? TRAIN_UP : TRAIN_DOWN;
    choice_wr = res_valid && (res_local != res_global);
    choice_op = (res_global == res_taken) ? TRAIN_UP : TRAIN_DOWN;
  end

  tbp_hist_table #(.IDX_W(LHT_IDX_W), .H_W(LH_W)) u_lht (
    .clk(clk), .rst_n(rst_n), .rd_idx(pred_lht_idx), .rd_hist(lhist),
    .wr_en(res_valid), .wr_idx(res_lht_idx), .wr_bit(res_taken));

  tbp_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W)) u_lpt (
    .clk(clk), .rst_n(rst_n), .rd_idx(lhist), .rd_ctr(lctr),
    .wr_en(res_valid), .wr_idx(res_lhist), .wr_op(dir_op));

  tbp_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W)) u_gpt (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .rd_ctr(gctr),
    .wr_en(res_valid), .wr_idx(res_ghist), .wr_op(dir_op));

  tbp_ctr_table #(.IDX_W(GH_W), .CTR_W(CCTR_W)) u_cpt (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .rd_ctr(cctr),
    .wr_en(choice_wr), .wr_idx(res_ghist), .wr_op(choice_op));

  tbp_ghr #(.GH_W(GH_W)) u_ghr (
    .clk(clk), .rst_n(rst_n),
    .spec_en(pred_valid), .spec_bit(pred_taken),
    .fix_en(res_valid && res_mispredict), .fix_hist(res_ghist), .fix_bit(res_taken),
    .hist(ghist));

  always_comb begin
    pred_local      = lctr[LCTR_W-1];
    pred_global     = gctr[GCTR_W-1];
    pred_use_global = cctr[CCTR_W-1];
    pred_taken      = pred_use_global ? pred_global : pred_local;
    pred_ghist      = ghist;
    pred_lhist      = lhist;
  end
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int PC_W = 32,
  parameter int GH_W = 12,
  parameter int LH_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pred_valid,
  input logic [PC_W-1:0] pred_pc,
  input logic            pred_taken,
  input logic [GH_W-1:0] pred_ghist,
  input logic [LH_W-1:0] pred_lhist,
  input logic            res_valid,
  input logic            res_taken,
  input logic            res_mispredict,
  input logic [GH_W-1:0] res_ghist
);
  p_ghr_spec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pred_valid) && !$past(res_valid && res_mispredict))
      |-> pred_ghist == {$past(pred_ghist[GH_W-2:0]), $past(pred_taken)});

  p_ghr_repair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(res_valid && res_mispredict))
      |-> pred_ghist == {$past(res_ghist[GH_W-2:0]), $past(res_taken)});

  p_ghr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pred_valid) && !$past(res_valid && res_mispredict))
      |-> $stable(pred_ghist));

  p_tables_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(res_valid) && $stable(pred_pc) && $stable(pred_ghist))
      |-> ($stable(pred_taken) && $stable(pred_lhist)));
endmodule

bind tournament_bp tbp_checker #(.PC_W(PC_W), .GH_W(GH_W), .LH_W(LH_W)) u_tbp_checker (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
  .pred_taken(pred_taken), .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
  .res_valid(res_valid), .res_taken(res_taken), .res_mispredict(res_mispredict),
  .res_ghist(res_ghist));

// File: tb/test_tournament_bp.sv
module test_tournament_bp;
  localparam int PC_W = 8, PC_SKIP = 2, LHT_IDX_W = 2, LH_W = 3, LCTR_W = 3;
  localparam int GH_W = 3, GCTR_W = 2, CCTR_W = 2;
  localparam int NBATCH = 500;

  logic clk, rst_n;
  logic pred_valid;
  logic [PC_W-1:0] pred_pc;
  logic pred_taken, pred_local, pred_global, pred_use_global;
  logic [GH_W-1:0] pred_ghist;
  logic [LH_W-1:0] pred_lhist;
  logic res_valid, res_taken, res_mispredict, res_local, res_global;
  logic [PC_W-1:0] res_pc;
  logic [GH_W-1:0] res_ghist;
  logic [LH_W-1:0] res_lhist;

  tournament_bp #(.PC_W(PC_W), .PC_SKIP(PC_SKIP), .LHT_IDX_W(LHT_IDX_W), .LH_W(LH_W),
    .LCTR_W(LCTR_W), .GH_W(GH_W), .GCTR_W(GCTR_W), .CCTR_W(CCTR_W)) i_tournament_bp (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
    .pred_use_global(pred_use_global), .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_mispredict(res_mispredict), .res_ghist(res_ghist), .res_lhist(res_lhist),
    .res_local(res_local), .res_global(res_global));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [LH_W-1:0]   m_lht [1 << LHT_IDX_W];
  logic [LCTR_W-1:0] m_lct [1 << LH_W];
  logic [GCTR_W-1:0] m_gct [1 << GH_W];
  logic [CCTR_W-1:0] m_cct [1 << GH_W];
  logic [GH_W-1:0]   m_ghr;
  int cnt [8];

  // per batch in-flight records
  logic [PC_W-1:0] q_pc [3];
  logic [GH_W-1:0] q_gh [3];
  logic [LH_W-1:0] q_lh [3];
  logic q_l [3], q_g [3], q_p [3], q_act [3];

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int step(input int v, input int maxv, input bit up);
    if (up) return (v == maxv) ? v : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1 << LHT_IDX_W); i++) m_lht[i] = '0;
    for (int i = 0; i < (1 << LH_W); i++) m_lct[i] = 3'd3;
    for (int i = 0; i < (1 << GH_W); i++) begin m_gct[i] = 2'd1; m_cct[i] = 2'd1; end
    m_ghr = '0;
  endtask

  // check outputs for a given pc against the model; returns the final prediction
  task automatic check_pred(input logic [PC_W-1:0] pc, output logic lh_o,
                            output logic [LH_W-1:0] lhist_o, output logic l_o, output logic g_o);
    int idx;
    logic [LH_W-1:0] lh;
    logic l, g, u, t;
    idx = int'(pc[PC_SKIP +: LHT_IDX_W]);
    lh  = m_lht[idx];
    l   = m_lct[lh][LCTR_W-1];
    g   = m_gct[m_ghr][GCTR_W-1];
    u   = m_cct[m_ghr][CCTR_W-1];
    t   = u ? g : l;
    chk(int'(pred_lhist), int'(lh), "R2/R7 local history");
    chk(int'(pred_local), int'(l), "R2/R8 local component");
    chk(int'(pred_global), int'(g), "R2/R8 global component");
    chk(int'(pred_use_global), int'(u), "R3/R9 chooser select");
    chk(int'(pred_taken), int'(t), "R3 final prediction");
    chk(int'(pred_ghist), int'(m_ghr), "R4/R5/R6 global history");
    lh_o = t; lhist_o = lh; l_o = l; g_o = g;
  endtask

  task automatic model_resolve(input logic [PC_W-1:0] pc, input logic [GH_W-1:0] gh,
                               input logic [LH_W-1:0] lh, input logic l, input logic g,
                               input logic act, input logic mis);
    int idx;
    idx = int'(pc[PC_SKIP +: LHT_IDX_W]);
    m_lht[idx] = {m_lht[idx][LH_W-2:0], act};
    m_lct[lh]  = LCTR_W'(step(int'(m_lct[lh]), 7, act));
    m_gct[gh]  = GCTR_W'(step(int'(m_gct[gh]), 3, act));
    if (l != g) m_cct[gh] = CCTR_W'(step(int'(m_cct[gh]), 3, g == act));
    if (mis) m_ghr = {gh[GH_W-2:0], act};
  endtask

  function automatic logic outcome(input int pcn, input int c);
    case (pcn % 4)
      0: return 1'b1;
      1: return c[0];
      2: return (c % 3) != 0;
      default: return 1'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic p, l, g;
    logic [LH_W-1:0] lh;
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    rst_n = 1'b0; pred_valid = 0; pred_pc = '0; res_valid = 0; res_pc = '0;
    res_taken = 0; res_mispredict = 0; res_ghist = '0; res_lhist = '0;
    res_local = 0; res_global = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state seen at the ports
    #5;
    chk(int'(pred_taken), 0, "R1 reset prediction");
    chk(int'(pred_use_global), 0, "R1 reset chooser");
    chk(int'(pred_ghist), 0, "R1 reset global history");
    chk(int'(pred_lhist), 0, "R1 reset local history");

    for (int b = 0; b < NBATCH; b++) begin
      int k;
      k = 1 + int'($urandom % 3);
      for (int j = 0; j < k; j++) begin
        int pcn;
        @(negedge clk);
        pcn = int'($urandom % 6);
        pred_valid = 1; res_valid = 0;
        pred_pc = PC_W'(pcn * 4);
        #5;
        check_pred(pred_pc, p, lh, l, g);
        q_pc[j] = pred_pc; q_gh[j] = m_ghr; q_lh[j] = lh; q_l[j] = l; q_g[j] = g;
        q_p[j] = p; q_act[j] = outcome(pcn, cnt[pcn]);
        cnt[pcn]++;
        m_ghr = {m_ghr[GH_W-2:0], p};   // R4 speculative shift
      end
      for (int j = 0; j < k; j++) begin
        logic mis;
        @(negedge clk);
        mis = (q_p[j] != q_act[j]);
        pred_valid = 0; res_valid = 1;
        res_pc = q_pc[j]; res_taken = q_act[j]; res_mispredict = mis;
        res_ghist = q_gh[j]; res_lhist = q_lh[j]; res_local = q_l[j]; res_global = q_g[j];
        model_resolve(q_pc[j], q_gh[j], q_lh[j], q_l[j], q_g[j], q_act[j], mis);
        if (mis) break;   // younger in-flight branches are squashed
      end
      @(negedge clk);
      res_valid = 0;
      // R6/R10: idle cycle, outputs match model and hold
      #5;
      check_pred(pred_pc, p, lh, l, g);
    end

    // R5: repair collides with a new prediction; repair wins
    @(negedge clk);
    pred_valid = 1; pred_pc = 8'd4;
    res_valid = 1; res_pc = 8'd8; res_taken = 0; res_mispredict = 1;
    res_ghist = 3'b101; res_lhist = 3'b010; res_local = 1; res_global = 0;
    model_resolve(8'd8, 3'b101, 3'b010, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    pred_valid = 0; res_valid = 0;
    #5;
    chk(int'(pred_ghist), 2, "R5 repair priority over prediction");
    check_pred(pred_pc, p, lh, l, g);
    // R6: no prediction and no repair keeps history
    @(negedge clk);
    #5;
    chk(int'(pred_ghist), 2, "R6 history hold");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule